// File: doc/BRIEF.md
# Memory-Mapped Serial Receive/Transmit Device

This block is a byte-wide serial endpoint that a processor reaches through plain load and store cycles on a small word-addressed bus. It has two independent directions. The receive side presents bytes from an internal source, which is a sequence computed at elaboration. The transmit side accepts bytes and emits each one on a capture stream. Each direction has a ready flag and an interrupt enable. The matching interrupt output is a level that stays high while both are set.

After every accepted data access, the ready flag of that direction drops. It returns only after a pseudo-random gap of 4 to 31 cycles. An 8-bit linear feedback shift register advances every cycle and supplies that gap. When the receive source runs out, the receive side stops in a drained state and never becomes ready again.

Each direction runs a small state machine. The states are `CH_READY`, `CH_GAP` and `CH_DRAINED`, and the transitions are:
- `CH_READY` to `CH_GAP` on an accepted access, with the gap counter loaded.
- `CH_GAP` to `CH_READY` when the counter reaches its last cycle.
- `CH_READY` to `CH_DRAINED` when the receive side takes its final byte. The state machine has no exit from `CH_DRAINED`.

Top module: `serial_io_dev`

## Requirements
- R1: After reset both interrupt enables are 0 and both interrupt outputs are low. The receive ready flag is 1 when the source holds at least one byte, and the transmit ready flag is 1.
- R2: Register word offsets are as follows. Offset 0 is receive control, 1 is receive data, 2 is transmit control and 3 is transmit data. In each control word, bit 0 is ready and bit 1 is interrupt enable. All other control bits read as 0, and reading transmit data returns 0.
- R3: The ready flag is read-only. A store to a control word changes only the enable, which takes the value of write data bit 1.
- R4: Receive byte number i (counting from 0) reads as RX_BASE + i*RX_STEP, modulo 256. The defaults are 0x41 and 1, giving 0x41 through 0x48. The receive data word reads 0 while receive ready is low.
- R5: A load from receive data while receive ready is high consumes the byte. Ready is low on the next cycle and stays low for 4 to 31 cycles before it returns with the next byte. The exception is the last byte, covered by R10.
- R6: A store to transmit data while transmit ready is high puts that byte on the capture stream. The stream valid flag is high for exactly the next cycle. Transmit ready then stays low for 4 to 31 cycles.
- R7: A store to transmit data while transmit ready is low is ignored and produces no stream output.
- R8: Each interrupt output is high exactly while its enable and its ready flag are both set. It holds until the matching data access occurs.
- R9: Clearing an enable makes the matching interrupt output low on the next cycle.
- R10: After the last source byte is consumed, receive ready and the receive interrupt stay low permanently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | DATA_W | Store data |
| bus_rdata | output | DATA_W | Load data (combinational) |
| rx_irq | output | 1 | Receive interrupt level |
| tx_irq | output | 1 | Transmit interrupt level |
| tx_out_vld | output | 1 | Capture stream byte valid |
| tx_out_byte | output | DATA_W | Capture stream byte |

## Verification
The checker assumes the bus strobe is held for one cycle per access and is otherwise low. It also assumes that data loads are issued only from offset 1, so a receive take is always a deliberate consume. The bench drives every access for exactly one cycle from a falling edge and leaves one idle cycle between accesses. It reads data words only after polling readiness through the interrupt outputs or the control words. The gap bounds are checked as ranges, never as exact values, so the bench does not depend on the generator sequence.

// File: rtl/serial_io_pkg.sv
package serial_io_pkg;
    typedef enum logic [1:0] {
        CH_READY   = 2'd0,
        CH_GAP     = 2'd1,
        CH_DRAINED = 2'd2
    } chan_state_t;

    localparam logic [1:0] OFF_RX_CTRL = 2'd0;
    localparam logic [1:0] OFF_RX_DATA = 2'd1;
    localparam logic [1:0] OFF_TX_CTRL = 2'd2;
    localparam logic [1:0] OFF_TX_DATA = 2'd3;

    localparam int CTRL_RDY_BIT = 0;
    localparam int CTRL_IE_BIT  = 1;

    localparam int GAP_W   = 5;
    localparam int GAP_MIN = 4;
endpackage

// File: rtl/serial_gap_lfsr.sv
module serial_gap_lfsr
    import serial_io_pkg::*;
#(
    parameter logic [7:0] SEED = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [GAP_W-1:0] gap_o
);
    logic [7:0]       lfsr_q;
    logic             fb;
    logic [GAP_W-1:0] raw;

    assign fb  = lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3];
    assign raw = lfsr_q[GAP_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= (SEED == 8'h00) ? 8'h01 : SEED;
        else        lfsr_q <= {lfsr_q[6:0], fb};
    end

    always_comb begin
        if (raw < GAP_W'(GAP_MIN)) gap_o = raw + GAP_W'(GAP_MIN);
        else                       gap_o = raw;
    end
endmodule

// File: rtl/serial_chan_fsm.sv
module serial_chan_fsm
    import serial_io_pkg::*;
#(
    parameter bit LIMIT_EN = 1'b0,
    parameter int COUNT    = 1,
    localparam int CNT_W   = (COUNT < 2) ? 1 : $clog2(COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             ready_o,
    output logic             done_o,
    output logic [CNT_W-1:0] idx_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'((COUNT > 0) ? COUNT - 1 : 0);
    localparam chan_state_t INIT_ST = (LIMIT_EN && COUNT == 0) ? CH_DRAINED : CH_READY;

    chan_state_t      state_q, state_d;
    logic [GAP_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic             accept;
    logic             is_last;

    assign accept  = (state_q == CH_READY) && take_i;
    assign is_last = LIMIT_EN && (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= INIT_ST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_READY:   if (take_i) state_d = is_last ? CH_DRAINED : CH_GAP;
            CH_GAP:     if (cnt_q == GAP_W'(1)) state_d = CH_READY;
            CH_DRAINED: state_d = CH_DRAINED;
            default:    state_d = INIT_ST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            if (accept) begin
                cnt_q <= gap_i;
                idx_q <= idx_q + CNT_W'(1);
            end else if (state_q == CH_GAP) begin
                cnt_q <= cnt_q - GAP_W'(1);
            end
        end
    end

    always_comb begin
        ready_o = (state_q == CH_READY);
        done_o  = (state_q == CH_DRAINED);
        idx_o   = idx_q;
    end
endmodule

// File: rtl/serial_io_dev.sv
module serial_io_dev
    import serial_io_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                RX_COUNT = 8,
    parameter logic [DATA_W-1:0] RX_BASE  = 8'h41,
    parameter logic [DATA_W-1:0] RX_STEP  = 8'h01,
    parameter logic [7:0]        SEED     = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic              tx_out_vld,
    output logic [DATA_W-1:0] tx_out_byte
);
    localparam int RX_CNT_W = (RX_COUNT < 2) ? 1 : $clog2(RX_COUNT + 1);

    logic [GAP_W-1:0]    gap;
    logic                rx_rdy, rx_done, tx_rdy, tx_done;
    logic [RX_CNT_W-1:0] rx_idx;
    logic [0:0]          tx_idx;
    logic                rx_ie, tx_ie;
    logic                rx_take, tx_take;
    logic                rx_ctrl_wr, tx_ctrl_wr;
    logic [DATA_W-1:0]   rx_byte;

    assign rx_take    = bus_sel && !bus_we && (bus_addr == OFF_RX_DATA) && rx_rdy;
    assign tx_take    = bus_sel &&  bus_we && (bus_addr == OFF_TX_DATA) && tx_rdy;
    assign rx_ctrl_wr = bus_sel &&  bus_we && (bus_addr == OFF_RX_CTRL);
    assign tx_ctrl_wr = bus_sel &&  bus_we && (bus_addr == OFF_TX_CTRL);

    serial_gap_lfsr #(.SEED(SEED)) gap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .gap_o (gap)
    );

    serial_chan_fsm #(.LIMIT_EN(1'b1), .COUNT(RX_COUNT)) rx_ch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (rx_take),
        .gap_i   (gap),
        .ready_o (rx_rdy),
        .done_o  (rx_done),
        .idx_o   (rx_idx)
    );

    serial_chan_fsm #(.LIMIT_EN(1'b0), .COUNT(1)) tx_ch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (tx_take),
        .gap_i   (gap),
        .ready_o (tx_rdy),
        .done_o  (tx_done),
        .idx_o   (tx_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ie       <= 1'b0;
            tx_ie       <= 1'b0;
            tx_out_vld  <= 1'b0;
            tx_out_byte <= '0;
        end else begin
            if (rx_ctrl_wr) rx_ie <= bus_wdata[CTRL_IE_BIT];
            if (tx_ctrl_wr) tx_ie <= bus_wdata[CTRL_IE_BIT];
            tx_out_vld <= tx_take;
            if (tx_take) tx_out_byte <= bus_wdata;
        end
    end

    assign rx_byte = RX_BASE + RX_STEP * DATA_W'(rx_idx);

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_RX_CTRL: begin
                bus_rdata[CTRL_RDY_BIT] = rx_rdy;
                bus_rdata[CTRL_IE_BIT]  = rx_ie;
            end
            OFF_RX_DATA: if (rx_rdy) bus_rdata = rx_byte;
            OFF_TX_CTRL: begin
                bus_rdata[CTRL_RDY_BIT] = tx_rdy;
                bus_rdata[CTRL_IE_BIT]  = tx_ie;
            end
            default:     bus_rdata = '0;
        endcase
    end

    assign rx_irq = rx_ie && rx_rdy;
    assign tx_irq = tx_ie && tx_rdy && !tx_done;
endmodule

// File: rtl/serial_io_dev_chk.sv
module serial_io_dev_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rx_irq,
    input logic              tx_irq,
    input logic              tx_out_vld,
    input logic [DATA_W-1:0] tx_out_byte,
    input logic              rx_rdy,
    input logic              tx_rdy,
    input logic              rx_done
);
    logic       rx_ld, tx_st, rx_cw, tx_cw;
    logic [5:0] rx_low, tx_low;

    assign rx_ld = bus_sel && !bus_we && (bus_addr == 2'd1);
    assign tx_st = bus_sel &&  bus_we && (bus_addr == 2'd3);
    assign rx_cw = bus_sel &&  bus_we && (bus_addr == 2'd0);
    assign tx_cw = bus_sel &&  bus_we && (bus_addr == 2'd2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_low <= '0;
            tx_low <= '0;
        end else begin
            rx_low <= rx_rdy ? 6'd0 : ((rx_low == 6'd63) ? rx_low : rx_low + 6'd1);
            tx_low <= tx_rdy ? 6'd0 : ((tx_low == 6'd63) ? tx_low : tx_low + 6'd1);
        end
    end

    AST_RX_TAKE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ld && rx_rdy) |=> !rx_rdy) else $error("rx ready kept"); // R5
    AST_RX_GAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_rdy) |-> (rx_low >= 6'd4 && rx_low <= 6'd31)) else $error("rx gap"); // R5
    AST_TX_GAP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_rdy) |-> (tx_low >= 6'd4 && tx_low <= 6'd31)) else $error("tx gap"); // R6
    AST_TX_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_st && tx_rdy) |=> (tx_out_vld && tx_out_byte == $past(bus_wdata))) else $error("tx echo"); // R6
    AST_TX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_st && !tx_rdy) |=> !tx_out_vld) else $error("tx not ignored"); // R7
    AST_RX_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !rx_ld && !rx_cw) |=> rx_irq) else $error("rx irq dropped"); // R8
    AST_TX_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !tx_st && !tx_cw) |=> tx_irq) else $error("tx irq dropped"); // R8
    AST_RX_IE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cw && !bus_wdata[1]) |=> !rx_irq) else $error("rx irq after clear"); // R9
    AST_TX_IE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cw && !bus_wdata[1]) |=> !tx_irq) else $error("tx irq after clear"); // R9
    AST_RDY_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cw && rx_rdy) |=> rx_rdy) else $error("ctrl store moved ready"); // R3
    AST_DRAINED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (rx_done && !rx_rdy && !rx_irq)) else $error("drained left"); // R10
endmodule

bind serial_io_dev serial_io_dev_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .rx_irq      (rx_irq),
    .tx_irq      (tx_irq),
    .tx_out_vld  (tx_out_vld),
    .tx_out_byte (tx_out_byte),
    .rx_rdy      (rx_rdy),
    .tx_rdy      (tx_rdy),
    .rx_done     (rx_done)
);

// File: tb/serial_io_dev_tb.sv
module serial_io_dev_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rx_irq, tx_irq, tx_out_vld;
    logic [7:0] tx_out_byte;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    serial_io_dev dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .tx_out_vld(tx_out_vld),
        .tx_out_byte(tx_out_byte)
    );

    // Entry: bit 8 = 1 for a transmit store of bits 7:0, 0 for a receive load expecting bits 7:0
    localparam logic [8:0] VEC [12] = '{
        9'h041, 9'h1A5, 9'h042, 9'h043, 9'h100, 9'h044,
        9'h1FF, 9'h045, 9'h046, 9'h13C, 9'h047, 9'h048
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        #1;
    endtask

    task automatic wait_irq(input bit tx, output int n);
        n = 0;
        while (((tx ? tx_irq : rx_irq) == 1'b0) && n < 40) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    function automatic void finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                finish_run();
            end
        end
    end

    initial begin
        logic [7:0] d;
        int n;
        int rx_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(rx_irq == 1'b0 && tx_irq == 1'b0, "R1 irqs low", {rx_irq, tx_irq}, 0);
        bus_rd(2'd0, d); check(d == 8'h01, "R1 R2 rx ctrl", d, 8'h01);
        bus_rd(2'd2, d); check(d == 8'h01, "R1 R2 tx ctrl", d, 8'h01);
        bus_rd(2'd3, d); check(d == 8'h00, "R2 tx data reads 0", d, 0);
        // R3 / R8 / R9 enable handling
        bus_wr(2'd0, 8'h03);
        check(rx_irq == 1'b1, "R8 rx irq on", rx_irq, 1);
        bus_rd(2'd0, d); check(d == 8'h03, "R3 rx ctrl ie set", d, 8'h03);
        bus_wr(2'd0, 8'h00);
        check(rx_irq == 1'b0, "R9 rx irq cleared", rx_irq, 0);
        bus_rd(2'd0, d); check(d == 8'h01, "R3 ready kept", d, 8'h01);
        bus_wr(2'd2, 8'hFE);
        bus_rd(2'd2, d); check(d == 8'h03, "R3 R2 tx ctrl only ie", d, 8'h03);
        check(tx_irq == 1'b1, "R8 tx irq on", tx_irq, 1);
        bus_wr(2'd0, 8'h02);
        // table walk
        rx_seen = 0;
        foreach (VEC[i]) begin
            if (VEC[i][8]) begin
                wait_irq(1'b1, n);
                check(tx_irq == 1'b1, "R8 tx irq before store", tx_irq, 1);
                bus_wr(2'd3, VEC[i][7:0]);
                check(tx_out_vld == 1'b1 && tx_out_byte == VEC[i][7:0], "R6 stream byte",
                      tx_out_byte, VEC[i][7:0]);
                check(tx_irq == 1'b0, "R8 tx irq drops", tx_irq, 0);
                wait_irq(1'b1, n);
                check(n >= 4 && n <= 31, "R6 tx gap", n, 4);
            end else begin
                wait_irq(1'b0, n);
                check(rx_irq == 1'b1, "R8 rx irq before load", rx_irq, 1);
                bus_rd(2'd1, d);
                check(d == VEC[i][7:0], "R4 rx byte", d, VEC[i][7:0]);
                check(rx_irq == 1'b0, "R5 rx ready drops", rx_irq, 0);
                rx_seen++;
                if (rx_seen < 8) begin
                    wait_irq(1'b0, n);
                    check(n >= 4 && n <= 31, "R5 rx gap", n, 4);
                end
            end
        end
        // R7 store while not ready
        wait_irq(1'b1, n);
        bus_wr(2'd3, 8'h55);
        check(tx_out_vld && tx_out_byte == 8'h55, "R6 stream 55", tx_out_byte, 8'h55);
        bus_wr(2'd3, 8'h66);
        check(tx_out_vld == 1'b0, "R7 dropped store", tx_out_vld, 0);
        wait_irq(1'b1, n);
        bus_wr(2'd3, 8'h77);
        check(tx_out_vld && tx_out_byte == 8'h77, "R7 next store", tx_out_byte, 8'h77);
        // R10 drained
        n = 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk); #1;
            if (rx_irq) n++;
        end
        check(n == 0, "R10 rx stays low", n, 0);
        bus_rd(2'd0, d); check(d == 8'h02, "R10 rx ctrl drained", d, 8'h02);
        bus_rd(2'd1, d); check(d == 8'h00, "R4 data 0 when not ready", d, 0);
        bus_rd(2'd0, d); check(d == 8'h02, "R10 load had no effect", d, 8'h02);
        done = 1'b1;
        finish_run();
    end
endmodule